// File: doc/BRIEF.md
# Serial memory write-permission guard

This block decides whether a write to a small serial nonvolatile memory may go ahead. It holds the write-enable latch and two block-protect bits, watches the write-protect pin, and for every transaction that ends tells the sequencer whether a data-array write or a status write may be committed. The front end supplies an already decoded command kind and an end-of-transaction event. That event carries a flag saying whether the transaction ended cleanly: for the enable and disable commands this means the select line rose right after the eighth instruction bit. For writes it means it rose on a byte boundary after at least one data byte. The timed program cycle reports its completion back through `cycle_done`.

The enable latch is volatile. A power-on reset clears it, and so does a soft reset. The protect bits survive a soft reset and return to the `BP_INIT` value only on power-on. Protection combines two things. The first is a range decode of the target address: no protection, the top quarter, the top half, or the whole array. The second is a gate formed by the write-protect pin and the enable latch.

Top module: `sp_wr_guard`

## Requirements
- R1: After power-on reset, `wel` is 0 and `bp` equals `BP_INIT` (default 2'b00).
- R2: An end event with `term_clean`=1 and `cmd_kind`=3'd1 (enable) sets `wel` at the next clock edge. The same event with `term_clean`=0 leaves `wel` unchanged.
- R3: A clean end event with `cmd_kind`=3'd2 (disable) clears `wel` at the next clock edge.
- R4: While `wp_n` is 0, `wel` is cleared at the next edge and an enable command cannot set it.
- R5: A `cycle_done` pulse clears `wel` at the next clock edge.
- R6: `perm_status` is 1 exactly when `wp_n` is 1 and `wel` is 1.
- R7: With `bp`=00, no address is protected. With 01, addresses whose two top bits are 11 are protected (0x180–0x1FF). With 10, addresses whose top bit is 1 are protected (0x100–0x1FF). With 11, every address is protected. `perm_array` is `perm_status` AND the address is not protected.
- R8: A clean end event with `cmd_kind`=3'd4 (status write) raises `go_status` in that cycle if `perm_status` is 1. `bp` then takes `sr_data[3:2]` at the next edge, and `wel` stays set until `cycle_done`. Without permission, `go_status` stays 0 and `bp` is unchanged.
- R9: A clean end event with `cmd_kind`=3'd3 (array write) raises `go_array` only when `perm_array` is 1.
- R10: A soft reset (`rst_n`=0) clears `wel` but leaves `bp` unchanged.
- R11: Enable and disable commands act on `wel` whatever the value of `bp`, including 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low; clears the latch and loads the protect bits |
| rst_n | input | 1 | Synchronous soft reset, active low; clears the latch only |
| wp_n | input | 1 | Write-protect pin, active low |
| term_evt | input | 1 | One-cycle pulse at the end of a transaction |
| term_clean | input | 1 | The transaction ended on a valid bit count |
| cmd_kind | input | 3 | Decoded command: 1 enable, 2 disable, 3 array write, 4 status write, others none |
| addr | input | ADDR_W | Target array address of the write |
| sr_data | input | 8 | Status byte received by a status write |
| cycle_done | input | 1 | Pulse when the timed program cycle completes |
| wel | output | 1 | Write-enable latch |
| bp | output | 2 | Block-protect bits |
| perm_array | output | 1 | An array write to `addr` may be committed |
| perm_status | output | 1 | A status write may be committed |
| go_array | output | 1 | Commit pulse for an array write |
| go_status | output | 1 | Commit pulse for a status write |

## Verification
The bench builds the block with its defaults: `ADDR_W`=9, giving a 512-byte array, and `BP_INIT`=0. With those values the quarter and half boundaries fall at 0x180 and 0x100, so the addresses on either side of each line (0x17F/0x180 and 0x0FF/0x100) and the extremes 0x000 and 0x1FF can be driven directly. The latch is taken through every setting and clearing event. Soft reset and power-on are told apart by loading nonzero protect bits first.

// File: rtl/sp_wr_guard.sv
module sp_wr_guard #(
  parameter int unsigned ADDR_W  = 9,
  parameter logic [1:0]  BP_INIT = 2'b00
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              wp_n,
  input  logic              term_evt,
  input  logic              term_clean,
  input  logic [2:0]        cmd_kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        sr_data,
  input  logic              cycle_done,
  output logic              wel,
  output logic [1:0]        bp,
  output logic              perm_array,
  output logic              perm_status,
  output logic              go_array,
  output logic              go_status
);
  localparam logic [2:0] K_SET  = 3'd1;
  localparam logic [2:0] K_CLR  = 3'd2;
  localparam logic [2:0] K_ARR  = 3'd3;
  localparam logic [2:0] K_STAT = 3'd4;

  logic ok_end, locked;

  assign ok_end = term_evt && term_clean;

  always_comb begin
    unique case (bp)
      2'b00:   locked = 1'b0;
      2'b01:   locked = &addr[ADDR_W-1 -: 2];
      2'b10:   locked = addr[ADDR_W-1];
      default: locked = 1'b1;
    endcase
  end

  assign perm_status = wp_n && wel;
  assign perm_array  = perm_status && !locked;
  assign go_array    = ok_end && cmd_kind == K_ARR  && perm_array;
  assign go_status   = ok_end && cmd_kind == K_STAT && perm_status;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                          wel <= 1'b0;
    else if (!rst_n || !wp_n)            wel <= 1'b0;
    else if (cycle_done)                 wel <= 1'b0;
    else if (ok_end && cmd_kind == K_CLR) wel <= 1'b0;
    else if (ok_end && cmd_kind == K_SET) wel <= 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)         bp <= BP_INIT;
    else if (go_status) bp <= sr_data[3:2];
  end
endmodule

module sp_wr_guard_chk #(
  parameter int unsigned ADDR_W = 9
) (
  input logic              clk,
  input logic              por_n,
  input logic              rst_n,
  input logic              wp_n,
  input logic              term_evt,
  input logic              term_clean,
  input logic [2:0]        cmd_kind,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        sr_data,
  input logic              cycle_done,
  input logic              wel,
  input logic [1:0]        bp,
  input logic              perm_array,
  input logic              perm_status,
  input logic              go_array,
  input logic              go_status
);
  a_r2_set_on_clean: assert property (@(posedge clk) disable iff (!por_n)
    rst_n && wp_n && !cycle_done && term_evt && term_clean && cmd_kind == 3'd1 |=> wel);
  a_r2_unclean_hold: assert property (@(posedge clk) disable iff (!por_n)
    rst_n && wp_n && !cycle_done && term_evt && !term_clean |=> wel == $past(wel));
  a_r3_disable: assert property (@(posedge clk) disable iff (!por_n)
    term_evt && term_clean && cmd_kind == 3'd2 |=> !wel);
  a_r4_pin_clears: assert property (@(posedge clk) disable iff (!por_n)
    !wp_n |=> !wel);
  a_r5_done_clears: assert property (@(posedge clk) disable iff (!por_n)
    cycle_done |=> !wel);
  a_r6_status_gate: assert property (@(posedge clk) disable iff (!por_n)
    perm_status |-> wel && wp_n);
  a_r7_all_locked: assert property (@(posedge clk) disable iff (!por_n)
    bp == 2'b11 |-> !perm_array && !go_array);
  a_r8_bp_load: assert property (@(posedge clk) disable iff (!por_n)
    go_status |=> bp == $past(sr_data[3:2]));
  a_r8_bp_hold: assert property (@(posedge clk) disable iff (!por_n)
    !go_status |=> $stable(bp));
  a_r9_go_needs_perm: assert property (@(posedge clk) disable iff (!por_n)
    go_array |-> perm_array && term_evt);
  a_r10_soft_reset: assert property (@(posedge clk) disable iff (!por_n)
    !rst_n |=> !wel);
endmodule

bind sp_wr_guard sp_wr_guard_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_sp_wr_guard.sv
module tb_sp_wr_guard;
  localparam int CLK_P = 10;
  localparam int AW = 9;

  logic clk = 1'b0, por_n = 1'b0, rst_n = 1'b1, wp_n = 1'b1;
  logic term_evt = 1'b0, term_clean = 1'b0, cycle_done = 1'b0;
  logic [2:0] cmd_kind = 3'd0;
  logic [AW-1:0] addr = '0;
  logic [7:0] sr_data = 8'h00;
  logic wel, perm_array, perm_status, go_array, go_status;
  logic [1:0] bp;

  int checks = 0, errors = 0, cycles = 0;
  bit done_flag = 1'b0;

  typedef struct {
    string rq;
    logic wel, pa, ps, ga, gs;
    logic [1:0] bp;
  } exp_t;
  exp_t q[$];

  logic m_wel = 1'b0;
  logic [1:0] m_bp = 2'b00;

  sp_wr_guard #(.ADDR_W(AW), .BP_INIT(2'b00)) dut (.*);

  always #(CLK_P/2) clk = ~clk;

  function automatic logic prot(logic [1:0] b, logic [AW-1:0] a);
    case (b)
      2'b00: return 1'b0;
      2'b01: return a >= 9'h180;
      2'b10: return a >= 9'h100;
      default: return 1'b1;
    endcase
  endfunction

  task automatic cyc(string rq, logic [2:0] k, logic ev, logic cl, logic wp,
                     logic [AW-1:0] a, logic [7:0] d, logic dn, logic rs);
    exp_t e;
    logic ok;
    @(negedge clk);
    cmd_kind = k; term_evt = ev; term_clean = cl; wp_n = wp;
    addr = a; sr_data = d; cycle_done = dn; rst_n = rs;
    ok = ev && cl;
    e.rq = rq; e.wel = m_wel; e.bp = m_bp;
    e.ps = wp && m_wel;
    e.pa = e.ps && !prot(m_bp, a);
    e.ga = ok && k == 3'd3 && e.pa;
    e.gs = ok && k == 3'd4 && e.ps;
    q.push_back(e);
    if (!rs || !wp || dn) m_wel = 1'b0;
    else if (ok && k == 3'd2) m_wel = 1'b0;
    else if (ok && k == 3'd1) m_wel = 1'b1;
    if (e.gs) m_bp = d[3:2];
  endtask

  task automatic idle(string rq);
    cyc(rq, 3'd0, 1'b0, 1'b0, 1'b1, '0, 8'h00, 1'b0, 1'b1);
  endtask

  task automatic set_bp(string rq, logic [1:0] b);
    cyc(rq, 3'd1, 1'b1, 1'b1, 1'b1, '0, 8'h00, 1'b0, 1'b1);
    cyc(rq, 3'd4, 1'b1, 1'b1, 1'b1, '0, {4'h0, b, 2'b00}, 1'b0, 1'b1);
    cyc(rq, 3'd0, 1'b0, 1'b0, 1'b1, '0, 8'h00, 1'b1, 1'b1);
  endtask

  task automatic probe(string rq, logic [AW-1:0] a);
    cyc(rq, 3'd0, 1'b0, 1'b0, 1'b1, a, 8'h00, 1'b0, 1'b1);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (wel !== e.wel || bp !== e.bp || perm_array !== e.pa ||
            perm_status !== e.ps || go_array !== e.ga || go_status !== e.gs) begin
          errors++;
          $display("FAIL %s: got wel=%b bp=%b pa=%b ps=%b ga=%b gs=%b exp wel=%b bp=%b pa=%b ps=%b ga=%b gs=%b",
                   e.rq, wel, bp, perm_array, perm_status, go_array, go_status,
                   e.wel, e.bp, e.pa, e.ps, e.ga, e.gs);
        end
      end
    end
  end

  initial begin : watchdog
    while (!done_flag) begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        checks++; errors++;
        $display("FAIL watchdog: got running exp finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    #(CLK_P/4);
    checks++;
    if (wel !== 1'b0 || bp !== 2'b00) begin
      errors++;
      $display("FAIL R1: got wel=%b bp=%b exp wel=0 bp=00", wel, bp);
    end
    @(negedge clk); por_n = 1'b1;
    idle("R1");
    // R2: unclean then clean enable
    cyc("R2", 3'd1, 1'b1, 1'b0, 1'b1, '0, 8'h00, 1'b0, 1'b1);
    idle("R2");
    cyc("R2", 3'd1, 1'b1, 1'b1, 1'b1, '0, 8'h00, 1'b0, 1'b1);
    idle("R6");
    // R3
    cyc("R3", 3'd2, 1'b1, 1'b1, 1'b1, '0, 8'h00, 1'b0, 1'b1);
    idle("R3");
    // R8 without permission
    cyc("R8", 3'd4, 1'b1, 1'b1, 1'b1, '0, 8'h0C, 1'b0, 1'b1);
    idle("R8");
    // R8 permitted, wel held until done (R5)
    cyc("R8", 3'd1, 1'b1, 1'b1, 1'b1, '0, 8'h00, 1'b0, 1'b1);
    cyc("R8", 3'd4, 1'b1, 1'b1, 1'b1, '0, 8'h04, 1'b0, 1'b1);
    idle("R8");
    cyc("R5", 3'd0, 1'b0, 1'b0, 1'b1, '0, 8'h00, 1'b1, 1'b1);
    idle("R5");
    // R7 quarter
    cyc("R7", 3'd1, 1'b1, 1'b1, 1'b1, '0, 8'h00, 1'b0, 1'b1);
    probe("R7", 9'h17F); probe("R7", 9'h180); probe("R7", 9'h1FF); probe("R7", 9'h000);
    cyc("R9", 3'd3, 1'b1, 1'b1, 1'b1, 9'h17F, 8'h00, 1'b0, 1'b1);
    cyc("R9", 3'd3, 1'b1, 1'b1, 1'b1, 9'h180, 8'h00, 1'b0, 1'b1);
    cyc("R9", 3'd3, 1'b1, 1'b0, 1'b1, 9'h010, 8'h00, 1'b0, 1'b1);
    cyc("R5", 3'd0, 1'b0, 1'b0, 1'b1, '0, 8'h00, 1'b1, 1'b1);
    // R7 half
    set_bp("R7", 2'b10);
    cyc("R7", 3'd1, 1'b1, 1'b1, 1'b1, '0, 8'h00, 1'b0, 1'b1);
    probe("R7", 9'h0FF); probe("R7", 9'h100);
    // R4 pin low
    cyc("R4", 3'd0, 1'b0, 1'b0, 1'b0, 9'h000, 8'h00, 1'b0, 1'b1);
    cyc("R4", 3'd1, 1'b1, 1'b1, 1'b0, 9'h000, 8'h00, 1'b0, 1'b1);
    cyc("R4", 3'd3, 1'b1, 1'b1, 1'b0, 9'h000, 8'h00, 1'b0, 1'b1);
    idle("R4");
    // R7 all, R11 enable under full protection
    set_bp("R7", 2'b11);
    cyc("R11", 3'd1, 1'b1, 1'b1, 1'b1, '0, 8'h00, 1'b0, 1'b1);
    probe("R11", 9'h000); probe("R7", 9'h1FF);
    cyc("R11", 3'd2, 1'b1, 1'b1, 1'b1, '0, 8'h00, 1'b0, 1'b1);
    idle("R11");
    // R10 soft reset keeps bp
    cyc("R10", 3'd1, 1'b1, 1'b1, 1'b1, '0, 8'h00, 1'b0, 1'b1);
    cyc("R10", 3'd0, 1'b0, 1'b0, 1'b1, '0, 8'h00, 1'b0, 1'b0);
    idle("R10");
    // R7 none
    set_bp("R7", 2'b00);
    cyc("R7", 3'd1, 1'b1, 1'b1, 1'b1, '0, 8'h00, 1'b0, 1'b1);
    probe("R7", 9'h1FF);
    cyc("R9", 3'd3, 1'b1, 1'b1, 1'b1, 9'h1FF, 8'h00, 1'b0, 1'b1);
    idle("R9");
    repeat (3) @(negedge clk);
    done_flag = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule